// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block chooses, every clock cycle, at most one DRAM command to issue from a small queue of pending memory requests. Each queued request names a bank, a row and the thread that issued it, and carries a saturating age counter that grows while it waits. The scheduler keeps a table of which row, if any, is open in every bank. From that table it turns the chosen request into the next command it needs. A bank with no open row gets an activate. A bank with a different row open gets a precharge. A bank whose open row matches gets the column access (read or write), and the request leaves the queue at that point.

A two-bit policy input picks the selection order. The first order is oldest-ready-first. The second puts ready requests that hit an open row ahead of all others. The third adds a starvation override to the second: a thread with a request that has waited too long is served first. A separate close-page input makes the block precharge a bank right after a column access when no other queued request wants the same bank and row. A per-bank ready input says which banks may take a command this cycle. Detailed DRAM timing is left to whatever drives that input.

Top module: `rowhit_sched`

## Requirements
- R1: After a synchronous active-high reset, the queue is empty, every bank is closed and `cmd_valid_o` is 0 until a request has been accepted and selected.
- R2: An enqueue is placed in the lowest-numbered free slot with age 0. An enqueue that arrives while all DEPTH slots are occupied is discarded and never produces a command.
- R3: A selected request produces one of three commands. If its bank is closed, the command is activate (kind 1). If another row is open, it is precharge (kind 3). If its row is open, it is column access (kind 2). The request leaves the queue when its column access issues. At most one command issues per cycle, and kind 0 means no command.
- R4: With policy 0, the oldest queued request whose bank is ready is selected, whether or not it hits an open row.
- R5: With policy 1, the oldest ready request that hits its bank's open row is selected ahead of every non-hitting request. When there is no hit, the oldest ready request is selected.
- R6: A request whose `bank_ready_i` bit is 0 is never selected, and its entry stays queued until the bank becomes ready.
- R7: With policy 2 or 3, a thread is neglected while any of its queued requests has an age of at least STARVE (default 64). The oldest ready request of a neglected thread is selected ahead of row hits. When no thread is neglected, selection follows R5.
- R8: With `close_page_i` set, a column access that leaves no other queued request for the same bank and row is followed in the very next cycle by a precharge to that bank. That precharge is issued whatever the bank-ready bits are, and no other command issues in that cycle.
- R9: Each entry's age counts up by one per queued cycle and saturates at 2^AGE_W-1. "Oldest" means largest age, and equal ages resolve to the lowest slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 2 | 0 oldest-ready, 1 row-hit first, 2/3 row-hit first with starvation override |
| close_page_i | input | 1 | Early precharge after the last column access to a row |
| enq_valid_i | input | 1 | Enqueue strobe for one request |
| enq_bank_i | input | BANK_W | Bank of the request |
| enq_row_i | input | ROW_W | Row of the request |
| enq_tid_i | input | TID_W | Thread id of the request |
| bank_ready_i | input | NBANK | Per-bank permission to take a command this cycle |
| cmd_valid_o | output | 1 | A command issued this cycle (registered) |
| cmd_kind_o | output | 2 | 0 none, 1 activate, 2 column access, 3 precharge |
| cmd_idx_o | output | IDX_W | Queue slot of the request behind the command |
| cmd_bank_o | output | BANK_W | Target bank |
| cmd_row_o | output | ROW_W | Target row (activate and column access) |

## Verification
The hardest state to reach is a starved request competing against an open-row hit. The bench builds it in three steps. It first runs one request to open a row, then lowers every ready bit, queues a miss from one thread, and idles for about seventy cycles. Only after that does it queue a hit from another thread and release the banks. The same setup with a short wait, and again under policy 1, shows that the override depends on both policy and age. Age saturation is reached by idling more than 127 cycles with a younger request placed in a lower slot, which makes the tie rule visible in the command order.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_COL  = 2'd2,
    CMD_PRE  = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    POL_OLDEST  = 2'd0,
    POL_HITFST  = 2'd1,
    POL_FAIR    = 2'd2,
    POL_FAIR_B  = 2'd3
  } policy_e;
endpackage

// File: rtl/rsched_queue.sv
module rsched_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int TID_W  = 2,
  parameter int AGE_W  = 7,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             enq_valid,
  input  logic [BANK_W-1:0]                enq_bank,
  input  logic [ROW_W-1:0]                 enq_row,
  input  logic [TID_W-1:0]                 enq_tid,
  input  logic                             clr_valid,
  input  logic [IDX_W-1:0]                 clr_idx,
  output logic [DEPTH-1:0]                 q_valid,
  output logic [DEPTH-1:0][BANK_W-1:0]     q_bank,
  output logic [DEPTH-1:0][ROW_W-1:0]      q_row,
  output logic [DEPTH-1:0][TID_W-1:0]      q_tid,
  output logic [DEPTH-1:0][AGE_W-1:0]      q_age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic             free_found;
  logic [IDX_W-1:0] free_idx;

  // lowest free slot: descending scan lets the smallest index win
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!q_valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= '0;
      q_age   <= '0;
      q_bank  <= '0;
      q_row   <= '0;
      q_tid   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (q_valid[i] && q_age[i] != AGE_MAX)
          q_age[i] <= q_age[i] + AGE_W'(1);
        if (clr_valid && clr_idx == IDX_W'(i))
          q_valid[i] <= 1'b0;
        if (enq_valid && free_found && free_idx == IDX_W'(i)) begin
          q_valid[i] <= 1'b1;
          q_bank[i]  <= enq_bank;
          q_row[i]   <= enq_row;
          q_tid[i]   <= enq_tid;
          q_age[i]   <= '0;
        end
      end
    end
  end

  // removal must target a live entry
  assert_clr_live_R3: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> q_valid[clr_idx]);

  // a full queue stays full when nothing leaves
  assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
    ((&q_valid) && enq_valid && !clr_valid) |=> (&q_valid));

  for (genvar g = 0; g < DEPTH; g++) begin : g_age_chk
    assert_age_sat_R9: assert property (@(posedge clk) disable iff (rst)
      (q_valid[g] && q_age[g] == AGE_MAX && !(clr_valid && clr_idx == IDX_W'(g)))
      |=> q_age[g] == AGE_MAX);
  end
endmodule

// File: rtl/rsched_banks.sv
module rsched_banks
  import sched_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           upd_valid,
  input  cmd_kind_e                      upd_kind,
  input  logic [BANK_W-1:0]              upd_bank,
  input  logic [ROW_W-1:0]               upd_row,
  output logic [NBANK-1:0]               bank_open,
  output logic [NBANK-1:0][ROW_W-1:0]    open_row
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_open <= '0;
      open_row  <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (upd_valid && upd_bank == BANK_W'(b)) begin
          if (upd_kind == CMD_ACT) begin
            bank_open[b] <= 1'b1;
            open_row[b]  <= upd_row;
          end else if (upd_kind == CMD_PRE) begin
            bank_open[b] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rsched_pick.sv
module rsched_pick
  import sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  parameter int TID_W  = 2,
  parameter int AGE_W  = 7,
  parameter int STARVE = 64,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int NTHR   = 1 << TID_W
) (
  input  logic [DEPTH-1:0]               q_valid,
  input  logic [DEPTH-1:0][BANK_W-1:0]   q_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]    q_row,
  input  logic [DEPTH-1:0][TID_W-1:0]    q_tid,
  input  logic [DEPTH-1:0][AGE_W-1:0]    q_age,
  input  logic [NBANK-1:0]               bank_open,
  input  logic [NBANK-1:0][ROW_W-1:0]    open_row,
  input  logic [NBANK-1:0]               bank_ready,
  input  logic [1:0]                     policy,
  output logic                           sel_valid,
  output logic [IDX_W-1:0]               sel_idx,
  output cmd_kind_e                      sel_kind,
  output logic                           sel_shared
);
  logic [DEPTH-1:0] rdy, hit, starv;
  logic [NTHR-1:0]  neg_tid;
  logic [IDX_W:0]   res_rdy, res_hit, res_starv, pick;
  logic [BANK_W-1:0] sb;

  // oldest entry of a mask: largest age, lowest index on a tie
  function automatic logic [IDX_W:0] oldest(input logic [DEPTH-1:0] m,
                                            input logic [DEPTH-1:0][AGE_W-1:0] a);
    logic             found;
    logic [IDX_W-1:0] idx;
    logic [AGE_W-1:0] best;
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (m[i] && (!found || a[i] > best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = a[i];
      end
    end
    return {found, idx};
  endfunction

  always_comb begin
    neg_tid = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rdy[i] = q_valid[i] && bank_ready[q_bank[i]];
      hit[i] = rdy[i] && bank_open[q_bank[i]] && (open_row[q_bank[i]] == q_row[i]);
      if (q_valid[i] && int'(q_age[i]) >= STARVE)
        neg_tid[q_tid[i]] = 1'b1;
    end
    for (int i = 0; i < DEPTH; i++)
      starv[i] = rdy[i] && neg_tid[q_tid[i]];
  end

  always_comb begin
    res_rdy   = oldest(rdy, q_age);
    res_hit   = oldest(hit, q_age);
    res_starv = oldest(starv, q_age);
    case (policy)
      POL_OLDEST: pick = res_rdy;
      POL_HITFST: pick = res_hit[IDX_W] ? res_hit : res_rdy;
      default:    pick = res_starv[IDX_W] ? res_starv
                                          : (res_hit[IDX_W] ? res_hit : res_rdy);
    endcase
    sel_valid = pick[IDX_W];
    sel_idx   = pick[IDX_W-1:0];
    sb        = q_bank[sel_idx];
    if (!sel_valid)          sel_kind = CMD_NONE;
    else if (hit[sel_idx])   sel_kind = CMD_COL;
    else if (bank_open[sb])  sel_kind = CMD_PRE;
    else                     sel_kind = CMD_ACT;
    sel_shared = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (q_valid[i] && IDX_W'(i) != sel_idx && q_bank[i] == sb &&
          q_row[i] == q_row[sel_idx])
        sel_shared = 1'b1;
    end
  end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
  import sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  parameter int TID_W  = 2,
  parameter int AGE_W  = 7,
  parameter int STARVE = 64,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        policy_i,
  input  logic              close_page_i,
  input  logic              enq_valid_i,
  input  logic [BANK_W-1:0] enq_bank_i,
  input  logic [ROW_W-1:0]  enq_row_i,
  input  logic [TID_W-1:0]  enq_tid_i,
  input  logic [NBANK-1:0]  bank_ready_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_kind_o,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o
);
  logic [DEPTH-1:0]             q_valid;
  logic [DEPTH-1:0][BANK_W-1:0] q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  q_row;
  logic [DEPTH-1:0][TID_W-1:0]  q_tid;
  logic [DEPTH-1:0][AGE_W-1:0]  q_age;
  logic [NBANK-1:0]             bank_open;
  logic [NBANK-1:0][ROW_W-1:0]  open_row;

  logic              sel_valid, sel_shared;
  logic [IDX_W-1:0]  sel_idx;
  cmd_kind_e         sel_kind;

  logic              pend_pre;
  logic [BANK_W-1:0] pend_bank;
  logic [IDX_W-1:0]  pend_idx;

  logic              iss_valid, clr_valid, set_pend;
  cmd_kind_e         iss_kind;
  logic [IDX_W-1:0]  iss_idx;
  logic [BANK_W-1:0] iss_bank;
  logic [ROW_W-1:0]  iss_row;

  rsched_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
                 .TID_W(TID_W), .AGE_W(AGE_W)) u_queue (
    .clk, .rst,
    .enq_valid(enq_valid_i), .enq_bank(enq_bank_i), .enq_row(enq_row_i),
    .enq_tid(enq_tid_i), .clr_valid(clr_valid), .clr_idx(iss_idx),
    .q_valid, .q_bank, .q_row, .q_tid, .q_age
  );

  rsched_banks #(.NBANK(NBANK), .ROW_W(ROW_W)) u_banks (
    .clk, .rst,
    .upd_valid(iss_valid), .upd_kind(iss_kind), .upd_bank(iss_bank),
    .upd_row(iss_row), .bank_open, .open_row
  );

  rsched_pick #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .TID_W(TID_W),
                .AGE_W(AGE_W), .STARVE(STARVE)) u_pick (
    .q_valid, .q_bank, .q_row, .q_tid, .q_age, .bank_open, .open_row,
    .bank_ready(bank_ready_i), .policy(policy_i),
    .sel_valid, .sel_idx, .sel_kind, .sel_shared
  );

  // one command per cycle; a pending early precharge takes the slot
  always_comb begin
    iss_valid = 1'b0;
    iss_kind  = CMD_NONE;
    iss_idx   = sel_idx;
    iss_bank  = q_bank[sel_idx];
    iss_row   = q_row[sel_idx];
    clr_valid = 1'b0;
    set_pend  = 1'b0;
    if (pend_pre) begin
      iss_valid = 1'b1;
      iss_kind  = CMD_PRE;
      iss_idx   = pend_idx;
      iss_bank  = pend_bank;
      iss_row   = open_row[pend_bank];
    end else if (sel_valid) begin
      iss_valid = 1'b1;
      iss_kind  = sel_kind;
      if (sel_kind == CMD_COL) begin
        clr_valid = 1'b1;
        set_pend  = close_page_i && !sel_shared;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_pre    <= 1'b0;
      pend_bank   <= '0;
      pend_idx    <= '0;
      cmd_valid_o <= 1'b0;
      cmd_kind_o  <= CMD_NONE;
      cmd_idx_o   <= '0;
      cmd_bank_o  <= '0;
      cmd_row_o   <= '0;
    end else begin
      pend_pre <= set_pend;
      if (set_pend) begin
        pend_bank <= iss_bank;
        pend_idx  <= iss_idx;
      end
      cmd_valid_o <= iss_valid;
      cmd_kind_o  <= iss_kind;
      cmd_idx_o   <= iss_idx;
      cmd_bank_o  <= iss_bank;
      cmd_row_o   <= iss_row;
    end
  end

  assert_col_open_row_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_kind_o == CMD_COL) |->
      (bank_open[cmd_bank_o] && open_row[cmd_bank_o] == cmd_row_o));

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_kind_o == CMD_ACT) |->
      (bank_open[cmd_bank_o] && open_row[cmd_bank_o] == cmd_row_o));

  assert_pre_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_kind_o == CMD_PRE) |-> !bank_open[cmd_bank_o]);

  assert_kind_valid_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o == (cmd_kind_o != CMD_NONE));

  assert_close_pre_R8: assert property (@(posedge clk) disable iff (rst)
    pend_pre |=> (cmd_valid_o && cmd_kind_o == CMD_PRE));
endmodule

// File: tb/rowhit_sched_bench.sv
`timescale 1ns/1ps
module rowhit_sched_bench;
  localparam int DEPTH = 8, NBANK = 4, ROW_W = 8, TID_W = 2, AGE_W = 7, STARVE = 64;
  localparam int IDX_W = 3, BANK_W = 2;
  localparam logic [1:0] K_ACT = 2'd1, K_COL = 2'd2, K_PRE = 2'd3;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] policy = 2'd0;
  logic close_page = 1'b0, enq_valid = 1'b0;
  logic [BANK_W-1:0] enq_bank = '0;
  logic [ROW_W-1:0] enq_row = '0;
  logic [TID_W-1:0] enq_tid = '0;
  logic [NBANK-1:0] ready = '0;
  logic cmd_valid;
  logic [1:0] cmd_kind;
  logic [IDX_W-1:0] cmd_idx;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  rowhit_sched #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .TID_W(TID_W),
                 .AGE_W(AGE_W), .STARVE(STARVE)) u_rowhit_sched (
    .clk, .rst, .policy_i(policy), .close_page_i(close_page),
    .enq_valid_i(enq_valid), .enq_bank_i(enq_bank), .enq_row_i(enq_row),
    .enq_tid_i(enq_tid), .bank_ready_i(ready),
    .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind), .cmd_idx_o(cmd_idx),
    .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row)
  );

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enq_valid = 1'b0; ready = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic enq(input int b, input int r, input int t);
    @(negedge clk);
    enq_valid = 1'b1; enq_bank = BANK_W'(b); enq_row = ROW_W'(r); enq_tid = TID_W'(t);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  // expect one command on the next registered output
  task automatic chk(input logic [1:0] k, input int idx, input int b, input int r,
                     input string rq);
    @(negedge clk);
    checks++;
    if (!cmd_valid || cmd_kind != k || int'(cmd_bank) != b ||
        (k != K_PRE && (int'(cmd_idx) != idx || int'(cmd_row) != r))) begin
      failures++;
      $display("FAIL %s: got v=%0d kind=%0d idx=%0d bank=%0d row=%0d exp kind=%0d idx=%0d bank=%0d row=%0d",
               rq, cmd_valid, cmd_kind, cmd_idx, cmd_bank, cmd_row, k, idx, b, r);
    end
  endtask

  task automatic chk_none(input string rq);
    @(negedge clk);
    checks++;
    if (cmd_valid) begin
      failures++;
      $display("FAIL %s: got v=1 kind=%0d idx=%0d exp no command", rq, cmd_kind, cmd_idx);
    end
  endtask

  // open row 1 in bank 0, then age a miss from thread 1 against a hit from thread 0
  task automatic fair_case(input logic [1:0] pol, input int wait_cyc, input bit starve_first);
    do_reset();
    policy = pol; close_page = 1'b0; ready = '1;
    enq(0, 1, 0);
    chk(K_ACT, 0, 0, 1, "R3 warm act");
    chk(K_COL, 0, 0, 1, "R3 warm col");
    ready = '0;
    enq(0, 2, 1);
    repeat (wait_cyc) @(negedge clk);
    enq(0, 1, 0);
    ready = '1;
    if (starve_first) begin
      chk(K_PRE, 0, 0, 0, "R7 starved pre");
      chk(K_ACT, 0, 0, 2, "R7 starved act");
      chk(K_COL, 0, 0, 2, "R7 starved col");
      chk(K_PRE, 1, 0, 0, "R7 then pre");
      chk(K_ACT, 1, 0, 1, "R7 then act");
      chk(K_COL, 1, 0, 1, "R7 then col");
    end else begin
      chk(K_COL, 1, 0, 1, "R5/R7 hit first");
      chk(K_PRE, 0, 0, 0, "R5/R7 pre");
      chk(K_ACT, 0, 0, 2, "R5/R7 act");
      chk(K_COL, 0, 0, 2, "R5/R7 col");
    end
  endtask

  // younger request in slot 0, older in slot 1, optional saturation wait
  task automatic sat_case(input int wait_cyc, input bit low_first);
    do_reset();
    policy = 2'd0; close_page = 1'b0; ready = 4'b1000;
    enq(3, 3, 0);
    enq(2, 2, 0);
    repeat (4) @(negedge clk);
    enq(1, 1, 0);
    repeat (wait_cyc) @(negedge clk);
    ready = '1;
    if (low_first) begin
      chk(K_ACT, 0, 1, 1, "R9 tie act slot0");
      chk(K_COL, 0, 1, 1, "R9 tie col slot0");
      chk(K_ACT, 1, 2, 2, "R9 tie act slot1");
      chk(K_COL, 1, 2, 2, "R9 tie col slot1");
    end else begin
      chk(K_ACT, 1, 2, 2, "R9 older act");
      chk(K_COL, 1, 2, 2, "R9 older col");
      chk(K_ACT, 0, 1, 1, "R9 younger act");
      chk(K_COL, 0, 1, 1, "R9 younger col");
    end
  endtask

  initial begin
    do_reset();
    chk_none("R1 idle after reset");

    // R4 oldest-ready order
    policy = 2'd0;
    enq(0, 1, 0); enq(0, 2, 0); enq(0, 1, 0);
    ready = '1;
    chk(K_ACT, 0, 0, 1, "R4 act e0");
    chk(K_COL, 0, 0, 1, "R4 col e0");
    chk(K_PRE, 1, 0, 0, "R4 pre e1");
    chk(K_ACT, 1, 0, 2, "R4 act e1");
    chk(K_COL, 1, 0, 2, "R4 col e1");
    chk(K_PRE, 2, 0, 0, "R4 pre e2");
    chk(K_ACT, 2, 0, 1, "R4 act e2");
    chk(K_COL, 2, 0, 1, "R4 col e2");
    chk_none("R3 queue drained");

    // R5 row-hit first
    do_reset();
    policy = 2'd1;
    enq(0, 1, 0); enq(0, 2, 0); enq(0, 1, 0);
    ready = '1;
    chk(K_ACT, 0, 0, 1, "R5 act e0");
    chk(K_COL, 0, 0, 1, "R5 col e0");
    chk(K_COL, 2, 0, 1, "R5 hit e2 before e1");
    chk(K_PRE, 1, 0, 0, "R5 pre e1");
    chk(K_ACT, 1, 0, 2, "R5 act e1");
    chk(K_COL, 1, 0, 2, "R5 col e1");
    chk_none("R5 no early precharge when close off");

    // R6 bank readiness
    do_reset();
    policy = 2'd0;
    enq(1, 3, 0); enq(2, 5, 0);
    ready = 4'b0100;
    chk(K_ACT, 1, 2, 5, "R6 ready bank only");
    chk(K_COL, 1, 2, 5, "R6 ready bank col");
    chk_none("R6 blocked bank waits");
    ready = '1;
    chk(K_ACT, 0, 1, 3, "R6 released act");
    chk(K_COL, 0, 1, 3, "R6 released col");

    // R8 close page
    do_reset();
    policy = 2'd1; close_page = 1'b1;
    enq(0, 1, 0); enq(0, 1, 0); enq(3, 2, 0);
    ready = '1;
    chk(K_ACT, 0, 0, 1, "R8 act");
    chk(K_COL, 0, 0, 1, "R8 col shared row");
    chk(K_COL, 1, 0, 1, "R8 col last user");
    chk(K_PRE, 1, 0, 0, "R8 early pre bank0");
    chk(K_ACT, 2, 3, 2, "R8 act bank3");
    chk(K_COL, 2, 3, 2, "R8 col bank3");
    chk(K_PRE, 2, 3, 0, "R8 early pre bank3");
    chk_none("R8 idle");
    close_page = 1'b0;

    // R7 starvation override
    fair_case(2'd2, 70, 1'b1);
    fair_case(2'd2, 10, 1'b0);
    fair_case(2'd1, 70, 1'b0);

    // R9 saturation and tie rule
    sat_case(20, 1'b0);
    sat_case(200, 1'b1);

    // R2 full queue drops the ninth request
    do_reset();
    policy = 2'd1;
    for (int i = 0; i < 9; i++) enq(0, 5, 0);
    ready = '1;
    chk(K_ACT, 0, 0, 5, "R2 act");
    for (int i = 0; i < 8; i++) chk(K_COL, i, 0, 5, "R2 col in slot order");
    chk_none("R2 ninth dropped");
    chk_none("R2 ninth dropped later");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule